// File: doc/BRIEF.md
# Master Clock Selector and Prescaler

This block builds the master clock that every downstream consumer uses. It selects one of four free-running input clocks (slow, main, PLL A, PLL B) and passes that clock through a prescaler that divides by any power of two from 1 to 64, or by 3. Software sets both choices with a single configuration write on the bus-side clock.

A switch between sources never leaves a runt pulse on the output. The old source is gated off on its own falling edge. Only after that shutdown has been seen back in the control domain is the new source allowed to start, again on its own falling edge. Each configuration write drops a ready flag at once. The flag rises again only after the new source is running and the prescaler has taken the new ratio. The ready flag, when enabled, drives an interrupt request.

Top module: `mck_master`

## Requirements
- R1: The source field selects the master clock source: 0 gives the slow clock, 1 the main clock, 2 PLL A and 3 PLL B.
- R2: Prescaler codes 0 to 6 divide the selected clock by 2^code. Code 0 passes the clock straight through, and codes 1 to 6 give a 50% duty cycle. Code 7 divides by 3, with the output high for one source period and low for two.
- R3: A configuration write clears the ready output on the next bus clock edge.
- R4: Ready returns to 1 only once the selected source is the one enabled and the prescaler has loaded the written ratio, so the output already runs at the new frequency when ready is seen high.
- R5: A source change never produces an output pulse shorter than half a period of the fastest source, and at no time are two sources enabled together.
- R6: A configuration write made before ready has returned restarts the sequence, and the last written setting is the one that takes effect.
- R7: After reset the output is the main clock divided by 1, ready is 1 and the interrupt enable is 0.
- R8: The interrupt output equals ready AND the interrupt-enable bit. A write to the enable bit changes neither ready nor the output clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-side control clock |
| rst | input | 1 | Synchronous active-high reset, held while all clocks run |
| clk_slow | input | 1 | Slow source clock (code 0) |
| clk_main | input | 1 | Main source clock (code 1) |
| clk_plla | input | 1 | PLL A source clock (code 2) |
| clk_pllb | input | 1 | PLL B source clock (code 3) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src | input | 2 | Source code written with cfg_wr |
| cfg_pres | input | 3 | Prescaler code written with cfg_wr |
| ien_wr | input | 1 | Interrupt-enable write strobe |
| ien_val | input | 1 | Interrupt-enable value written with ien_wr |
| mck | output | 1 | Master clock output |
| mck_ready | output | 1 | New setting established |
| mck_irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every source against every prescaler code and times the output period and high time in simulated time. A wrong divide table or a lopsided divide-by-3 therefore shows up as a wrong duration. It watches every output pulse during source-only switches at divide-by-1, where a careless hand-off would leave a sliver narrower than any source's half period. It writes a second setting while the first is still in flight, so a design that latches the stale request, or raises ready for the first one, reports the wrong period. It also checks that ready drops on the cycle right after a write and that writing the enable bit leaves ready and the clock alone.

// File: rtl/mck_pkg.sv
package mck_pkg;

    localparam int MCK_SRC_N  = 4;
    localparam int MCK_SEL_W  = $clog2(MCK_SRC_N);
    localparam int MCK_PRES_W = 3;
    localparam int MCK_CNT_W  = 6;

    localparam logic [MCK_PRES_W-1:0] DIV3_CODE = 3'd7;

    typedef logic [MCK_SEL_W-1:0]  src_t;
    typedef logic [MCK_PRES_W-1:0] pres_t;
    typedef logic [MCK_SRC_N-1:0]  src_vec_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWITCH = 2'd1,
        ST_LOAD   = 2'd2
    } ctrl_state_t;

    typedef struct packed {
        src_t  src;
        pres_t pres;
    } mck_cfg_t;

    function automatic src_vec_t src_onehot(input src_t s);
        src_vec_t v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    // terminal count of the half-period counter for a power-of-two code
    function automatic logic [MCK_CNT_W-1:0] half_term(input pres_t p);
        logic [MCK_CNT_W:0] half;
        half = (MCK_CNT_W+1)'(1) << (p - 3'd1);
        return half[MCK_CNT_W-1:0] - 1'b1;
    endfunction

endpackage

// File: rtl/mck_src_gate.sv
module mck_src_gate #(
    parameter logic RST_EN = 1'b0
) (
    input  logic clk_src,
    input  logic rst,
    input  logic en_req,
    output logic en
);
    logic sync_a;
    logic sync_b;

    always_ff @(posedge clk_src) begin
        if (rst) begin
            sync_a <= RST_EN;
            sync_b <= RST_EN;
        end else begin
            sync_a <= en_req;
            sync_b <= sync_a;
        end
    end

    // enable changes only while the source is low
    always_ff @(negedge clk_src) begin
        if (rst) en <= RST_EN;
        else     en <= sync_b;
    end
endmodule

// File: rtl/mck_prescaler.sv
module mck_prescaler
    import mck_pkg::*;
#(
    parameter int CNT_W = MCK_CNT_W
) (
    input  logic  clk_in,
    input  logic  rst,
    input  logic  ld_req,
    input  pres_t ld_pres,
    output logic  ld_ack,
    output logic  mck_out
);
    logic             rq_a, rq_b, rq_c;
    logic             load;
    pres_t            ratio;
    logic [CNT_W-1:0] cnt;
    logic             div_q;

    assign load = rq_b ^ rq_c;

    always_ff @(posedge clk_in) begin
        if (rst) begin
            rq_a   <= 1'b0;
            rq_b   <= 1'b0;
            rq_c   <= 1'b0;
            ld_ack <= 1'b0;
            ratio  <= '0;
            cnt    <= '0;
            div_q  <= 1'b0;
        end else begin
            rq_a <= ld_req;
            rq_b <= rq_a;
            rq_c <= rq_b;
            if (load) begin
                ratio  <= ld_pres;
                cnt    <= '0;
                div_q  <= 1'b0;
                ld_ack <= rq_b;
            end else if (ratio == DIV3_CODE) begin
                cnt   <= (cnt == CNT_W'(2)) ? '0 : cnt + 1'b1;
                div_q <= (cnt == CNT_W'(2));
            end else if (ratio != '0) begin
                if (cnt == half_term(ratio)) begin
                    cnt   <= '0;
                    div_q <= ~div_q;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    always_comb begin
        mck_out = (ratio == '0) ? clk_in : div_q;
    end

    AST_DIV3_RANGE: assert property (@(posedge clk_in) disable iff (rst)
        (ratio == DIV3_CODE) |-> (cnt <= CNT_W'(2)));          // R2
    AST_DIV3_SHORT_HIGH: assert property (@(posedge clk_in) disable iff (rst)
        (ratio == DIV3_CODE && div_q && !load) |=> !div_q);      // R2
endmodule

// File: rtl/mck_ctrl.sv
module mck_ctrl
    import mck_pkg::*;
#(
    parameter int   SRC_N   = MCK_SRC_N,
    parameter src_t RST_SRC = src_t'(1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  src_t             cfg_src,
    input  pres_t            cfg_pres,
    input  logic             ien_wr,
    input  logic             ien_val,
    input  logic [SRC_N-1:0] en_fb,
    input  logic             ld_ack,
    output logic [SRC_N-1:0] en_req,
    output logic             ld_req,
    output pres_t            ld_pres,
    output logic             ready,
    output logic             irq
);
    mck_cfg_t         cfg_q;
    ctrl_state_t      state;
    logic [SRC_N-1:0] fb_a, fb_b;
    logic             ack_a, ack_b;
    logic             ien;
    logic [SRC_N-1:0] rst_vec;
    logic [SRC_N-1:0] want;

    assign rst_vec = src_onehot(RST_SRC);
    assign want    = src_onehot(cfg_q.src);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.src  <= RST_SRC;
            cfg_q.pres <= '0;
            state      <= ST_IDLE;
            fb_a       <= rst_vec;
            fb_b       <= rst_vec;
            ack_a      <= 1'b0;
            ack_b      <= 1'b0;
            en_req     <= rst_vec;
            ld_req     <= 1'b0;
            ready      <= 1'b1;
            ien        <= 1'b0;
        end else begin
            fb_a  <= en_fb;
            fb_b  <= fb_a;
            ack_a <= ld_ack;
            ack_b <= ack_a;

            // a request, once raised, is held until its branch confirms it
            for (int i = 0; i < SRC_N; i++) begin
                if (en_req[i])
                    en_req[i] <= want[i] || !fb_b[i];
                else
                    en_req[i] <= want[i]
                              && ((fb_b & ~rst_vec_free(i)) == '0)
                              && ((en_req & ~rst_vec_free(i)) == '0);
            end

            if (ien_wr) ien <= ien_val;

            if (cfg_wr) begin
                cfg_q.src  <= cfg_src;
                cfg_q.pres <= cfg_pres;
                ready      <= 1'b0;
                state      <= ST_SWITCH;
            end else begin
                case (state)
                    ST_SWITCH: if (fb_b == want && ack_b == ld_req) begin
                        ld_req <= ~ld_req;
                        state  <= ST_LOAD;
                    end
                    ST_LOAD: if (ack_b == ld_req) begin
                        ready <= 1'b1;
                        state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    function automatic logic [SRC_N-1:0] rst_vec_free(input int k);
        logic [SRC_N-1:0] v;
        v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    assign ld_pres = cfg_q.pres;
    assign irq     = ready & ien;

    AST_WR_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !ready);                                      // R3
    AST_READY_ON_TARGET: assert property (@(posedge clk) disable iff (rst)
        ready |-> (fb_b == want));                               // R4
    AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(state == ST_LOAD));               // R4
    AST_SINGLE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fb_b));                                         // R5
endmodule

// File: rtl/mck_master.sv
module mck_master
    import mck_pkg::*;
#(
    parameter int   SRC_N   = MCK_SRC_N,
    parameter src_t RST_SRC = src_t'(1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_slow,
    input  logic       clk_main,
    input  logic       clk_plla,
    input  logic       clk_pllb,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_src,
    input  logic [2:0] cfg_pres,
    input  logic       ien_wr,
    input  logic       ien_val,
    output logic       mck,
    output logic       mck_ready,
    output logic       mck_irq
);
    logic [SRC_N-1:0] src_clk;
    logic [SRC_N-1:0] en_req;
    logic [SRC_N-1:0] en;
    logic             mux_clk;
    logic             ld_req;
    logic             ld_ack;
    pres_t            ld_pres;

    assign src_clk = {clk_pllb, clk_plla, clk_main, clk_slow};

    mck_ctrl #(.SRC_N(SRC_N), .RST_SRC(RST_SRC)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cfg_wr  (cfg_wr),
        .cfg_src (cfg_src),
        .cfg_pres(cfg_pres),
        .ien_wr  (ien_wr),
        .ien_val (ien_val),
        .en_fb   (en),
        .ld_ack  (ld_ack),
        .en_req  (en_req),
        .ld_req  (ld_req),
        .ld_pres (ld_pres),
        .ready   (mck_ready),
        .irq     (mck_irq)
    );

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        mck_src_gate #(.RST_EN(g == int'(RST_SRC))) u_gate (
            .clk_src(src_clk[g]),
            .rst    (rst),
            .en_req (en_req[g]),
            .en     (en[g])
        );
    end

    assign mux_clk = |(src_clk & en);

    mck_prescaler u_pres (
        .clk_in (mux_clk),
        .rst    (rst),
        .ld_req (ld_req),
        .ld_pres(ld_pres),
        .ld_ack (ld_ack),
        .mck_out(mck)
    );
endmodule

// File: tb/mck_master_test.sv
`timescale 1ns/1ps
module mck_master_test;
    localparam real CLK_PERIOD = 8.0;
    localparam real HALF_SLOW  = 25.0;
    localparam real HALF_MAIN  = 5.0;
    localparam real HALF_PLLA  = 3.0;
    localparam real HALF_PLLB  = 7.0;
    localparam real TOL        = 0.01;

    logic clk = 0, rst = 1;
    logic clk_slow = 0, clk_main = 0, clk_plla = 0, clk_pllb = 0;
    logic cfg_wr = 0, ien_wr = 0, ien_val = 0;
    logic [1:0] cfg_src = 0;
    logic [2:0] cfg_pres = 0;
    logic mck, mck_ready, mck_irq;

    int checks = 0, errors = 0;
    real meas_per, meas_high;
    bit  mon_on = 0;
    real min_pulse = 1.0e9;
    real last_edge = 0.0;

    always #(CLK_PERIOD/2.0) clk = ~clk;
    always #(HALF_SLOW) clk_slow = ~clk_slow;
    always #(HALF_MAIN) clk_main = ~clk_main;
    always #(HALF_PLLA) clk_plla = ~clk_plla;
    always #(HALF_PLLB) clk_pllb = ~clk_pllb;

    mck_master uut (
        .clk(clk), .rst(rst), .clk_slow(clk_slow), .clk_main(clk_main),
        .clk_plla(clk_plla), .clk_pllb(clk_pllb), .cfg_wr(cfg_wr),
        .cfg_src(cfg_src), .cfg_pres(cfg_pres), .ien_wr(ien_wr),
        .ien_val(ien_val), .mck(mck), .mck_ready(mck_ready), .mck_irq(mck_irq)
    );

    always @(mck) begin
        if (mon_on && ($realtime - last_edge) < min_pulse)
            min_pulse = $realtime - last_edge;
        last_edge = $realtime;
    end

    function automatic real src_half(input int s);
        case (s)
            0: return HALF_SLOW;
            1: return HALF_MAIN;
            2: return HALF_PLLA;
            default: return HALF_PLLB;
        endcase
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_time(input string req, input real act, input real exp);
        checks++;
        if (act < exp - TOL || act > exp + TOL) begin
            errors++;
            $display("FAIL %s: got %0.3f ns expected %0.3f ns", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int s, input int p);
        @(negedge clk);
        cfg_src = 2'(s); cfg_pres = 3'(p); cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!mck_ready && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check_bit(req, mck_ready, 1'b1);
    endtask

    task automatic measure();
        real t0, t1, t2;
        repeat (2) @(posedge mck);
        t0 = $realtime;
        @(negedge mck);
        t1 = $realtime;
        @(posedge mck);
        t2 = $realtime;
        meas_per  = t2 - t0;
        meas_high = t1 - t0;
    endtask

    task automatic expect_clock(input string req, input int s, input int p);
        real ph, per, hi;
        ph = src_half(s);
        if (p == 7) begin
            per = 6.0 * ph; hi = 2.0 * ph;
        end else begin
            per = 2.0 * ph * real'(1 << p);
            hi  = per / 2.0;
        end
        measure();
        check_time({req, " period"}, meas_per, per);
        check_time({req, " high"}, meas_high, hi);
    endtask

    initial begin
        repeat (30) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);

        // R7: reset state
        check_bit("R7 ready after reset", mck_ready, 1'b1);
        check_bit("R7 irq after reset", mck_irq, 1'b0);
        expect_clock("R7 main /1", 1, 0);

        // R8: enable write drives irq, leaves ready and clock alone
        @(negedge clk); ien_wr = 1; ien_val = 1;
        @(negedge clk); ien_wr = 0;
        check_bit("R8 irq enabled", mck_irq, 1'b1);
        check_bit("R8 ready unchanged", mck_ready, 1'b1);
        expect_clock("R8 clock unchanged", 1, 0);

        // R1 R2 R3 R4 R8: full sweep of sources and codes
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 8; p++) begin
                write_cfg(s, p);
                check_bit("R3 ready cleared", mck_ready, 1'b0);
                check_bit("R8 irq low while not ready", mck_irq, 1'b0);
                wait_ready("R4 ready returns");
                check_bit("R8 irq with ready", mck_irq, 1'b1);
                expect_clock("R1 R2 sweep", s, p);
            end
        end

        // R6: second write while the first is pending
        write_cfg(0, 5);
        repeat (3) @(negedge clk);
        check_bit("R6 still pending", mck_ready, 1'b0);
        write_cfg(2, 7);
        wait_ready("R6 ready after restart");
        expect_clock("R6 last write wins", 2, 7);

        // R6: restart during a pending prescaler reload on the same source
        write_cfg(2, 3);
        @(negedge clk);
        write_cfg(2, 1);
        wait_ready("R6 ready after reload restart");
        expect_clock("R6 reload restart", 2, 1);

        // R5: glitch watch over source-only switches at /1
        write_cfg(1, 0);
        wait_ready("R5 setup");
        for (int k = 0; k < 8; k++) begin
            int s;
            s = (k * 3 + 2) % 4;
            @(negedge clk);
            min_pulse = 1.0e9;
            mon_on = 1;
            write_cfg(s, 0);
            wait_ready("R5 switch ready");
            repeat (3) @(posedge mck);
            mon_on = 0;
            checks++;
            if (min_pulse < HALF_PLLA - TOL) begin
                errors++;
                $display("FAIL R5 runt pulse: got %0.3f ns expected >= %0.3f ns",
                         min_pulse, HALF_PLLA);
            end
            expect_clock("R5 R1 after switch", s, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule